// File: doc/BRIEF.md
# SDRAM Command Front End

This block is the input stage of a two-bank synchronous DRAM device. On every rising clock edge it samples the chip select, the three command strobes (row strobe, column strobe, write enable), the clock enable, a bank select bit and an 11-bit multiplexed address. From these it produces a registered, decoded command code. It keeps a row latch for each bank and a single column latch. It records whether each bank is open, and it runs the clock-enable logic that freezes the device or puts it into power-down.

Downstream logic uses the registered outputs to act on the command accepted at the previous edge. That logic includes the array, the data path and the burst counter, none of which are part of this block. Clock enable takes effect one cycle late. The command sampled at the edge where clock enable is first seen low is still carried out, and every later edge is ignored until clock enable has been seen high again. Which frozen state the block enters depends on whether any bank is still open once that last command has been applied.

Top module: `sdcmd_front`

## Requirements
- R1: While reset is asserted and after its release, the block starts with cmd_code = 0 (no operation), both banks idle, cmd_bank, row_out and col_out all zero, and suspend, power_down and illegal all low.
- R2: With cs_n low on an accepted edge, the strobe levels {ras_n,cas_n,we_n} decode as follows: 011 is activate (code 1), 101 is read (2), 100 is write (3), 010 is precharge (4), 001 is auto-refresh (5), 000 is mode set (6) and 111 is no operation (0). The code appears on cmd_code in the cycle after that edge.
- R3: An edge with cs_n high yields code 0 and changes no latch and no bank state, whatever the levels on the strobes, the bank select and the address.
- R4: An accepted activate stores addr[10:0] as the row of bank ba, marks that bank active and sets cmd_bank to ba. row_out always shows the stored row of the bank held in cmd_bank.
- R5: An accepted read or write to an active bank stores addr[7:0] in col_out and ba in cmd_bank.
- R6: A read or write to an idle bank yields code 0 and leaves col_out and cmd_bank unchanged. It sets illegal, which then stays high until reset.
- R7: An accepted precharge with addr[10] low makes bank ba idle. With addr[10] high it makes every bank idle. In both cases cmd_bank is set to ba.
- R8: When cke is low at an edge, the command at that edge is still executed. If any bank is active after that command, suspend rises after the edge. While suspend is high, commands are ignored: they yield code 0 and leave the latches and the bank states untouched.
- R9: When cke is low at an edge and all banks are idle after that edge's command, power_down rises after the edge. While power_down is high, commands are ignored in the same way as under suspend. suspend and power_down are never high together.
- R10: An edge with cke high while suspended or powered down clears the flag after that edge, but the command at that edge is still ignored. Commands are accepted again from the next edge.
- R11: Mode set stores ba in cmd_bank and changes no bank state. Auto-refresh changes no latch and no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 1 | Bank select |
| addr | input | 11 | Multiplexed row/column address, bit 10 selects all banks on precharge |
| cmd_code | output | 3 | Registered decoded command code |
| cmd_bank | output | 1 | Latched bank of the last bank-addressed command |
| row_out | output | 11 | Stored row of the bank in cmd_bank |
| col_out | output | 8 | Latched column address |
| bank_active | output | 2 | Per-bank open flag |
| suspend | output | 1 | Clock suspended with a bank open |
| power_down | output | 1 | Powered down with all banks idle |
| illegal | output | 1 | Sticky flag for read or write to an idle bank |

## Verification
The bench tests the edge where cke first goes low while carrying an activate. A design that decided the frozen state from the bank state before the command would go into power-down there when it should suspend. The exit edge is checked with a read presented on it, which must be ignored. A design that reacted to cke with no delay would execute that read and move the column latch one cycle early. A deselect is driven with the mode-set strobe pattern and an all-ones address to catch a decoder that looks at the strobes while the chip is not selected. A read to an idle bank is issued to catch a design that updates the column or lets the illegal flag clear again.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    CK_RUN  = 2'd0,
    CK_SUSP = 2'd1,
    CK_PDN  = 2'd2
  } ckmode_e;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic accept,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (accept && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_bank_track.sv
module sdcmd_bank_track
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BA_W      = 1,
  parameter int ROW_W     = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  cmd_e                       cmd,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           row_in,
  input  logic                       all_sel,
  output logic [NUM_BANKS-1:0]       act_q,
  output logic [NUM_BANKS-1:0]       act_nxt,
  output logic [NUM_BANKS*ROW_W-1:0] rows_q
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             hit;
    logic [ROW_W-1:0] row_r;
    logic [ROW_W-1:0] row_n;

    assign hit = (ba == BA_W'(g));

    always_comb begin
      act_nxt[g] = act_q[g];
      row_n      = row_r;
      if (cmd == CMD_ACT && hit) begin
        act_nxt[g] = 1'b1;
        row_n      = row_in;
      end
      if (cmd == CMD_PRE && (all_sel || hit)) begin
        act_nxt[g] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q[g] <= 1'b0;
        row_r    <= '0;
      end else begin
        act_q[g] <= act_nxt[g];
        row_r    <= row_n;
      end
    end

    assign rows_q[g*ROW_W +: ROW_W] = row_r;
  end
endmodule

// File: rtl/sdcmd_cke_ctl.sv
module sdcmd_cke_ctl
  import sdcmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic idle_after,
  output logic accept,
  output logic suspend,
  output logic power_down
);
  ckmode_e mode_q;
  ckmode_e mode_n;

  always_comb begin
    mode_n = mode_q;
    if (cke) begin
      mode_n = CK_RUN;
    end else if (mode_q == CK_RUN) begin
      mode_n = idle_after ? CK_PDN : CK_SUSP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= CK_RUN;
    else        mode_q <= mode_n;
  end

  assign accept     = (mode_q == CK_RUN);
  assign suspend    = (mode_q == CK_SUSP);
  assign power_down = (mode_q == CK_PDN);
endmodule

// File: rtl/sdcmd_front.sv
module sdcmd_front
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int RST_SYNC  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 cke,
  input  logic                 ba,
  input  logic [ROW_W-1:0]     addr,
  output logic [2:0]           cmd_code,
  output logic                 cmd_bank,
  output logic [ROW_W-1:0]     row_out,
  output logic [COL_W-1:0]     col_out,
  output logic [NUM_BANKS-1:0] bank_active,
  output logic                 suspend,
  output logic                 power_down,
  output logic                 illegal
);
  localparam int BA_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int AP_BIT = ROW_W - 1;

  // reset: asserted at once, released after RST_SYNC clocks
  logic [RST_SYNC-1:0] rst_pipe;
  logic                rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[RST_SYNC-1];

  logic                       accept;
  cmd_e                       cmd_raw;
  cmd_e                       cmd_eff;
  logic [NUM_BANKS-1:0]       act_q;
  logic [NUM_BANKS-1:0]       act_nxt;
  logic [NUM_BANKS*ROW_W-1:0] rows_q;
  logic [BA_W-1:0]            ba_sel;
  logic                       bad_access;

  assign ba_sel = BA_W'(ba);

  sdcmd_decode u_dec (
    .accept (accept),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .cmd    (cmd_raw)
  );

  // column commands only reach an open bank
  always_comb begin
    bad_access = (cmd_raw == CMD_RD || cmd_raw == CMD_WR) && !act_q[ba_sel];
    cmd_eff    = bad_access ? CMD_NOP : cmd_raw;
  end

  sdcmd_bank_track #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W),
    .ROW_W     (ROW_W)
  ) u_banks (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cmd     (cmd_eff),
    .ba      (ba_sel),
    .row_in  (addr),
    .all_sel (addr[AP_BIT]),
    .act_q   (act_q),
    .act_nxt (act_nxt),
    .rows_q  (rows_q)
  );

  sdcmd_cke_ctl u_cke (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cke        (cke),
    .idle_after (act_nxt == '0),
    .accept     (accept),
    .suspend    (suspend),
    .power_down (power_down)
  );

  // output latches: next state
  cmd_e             cmd_q;
  logic [BA_W-1:0]  bank_q, bank_n;
  logic [COL_W-1:0] col_q, col_n;
  logic             ill_q, ill_n;
  logic             bank_en, col_en;

  always_comb begin
    bank_en = (cmd_eff == CMD_ACT) || (cmd_eff == CMD_RD) || (cmd_eff == CMD_WR) ||
              (cmd_eff == CMD_PRE) || (cmd_eff == CMD_MRS);
    col_en  = (cmd_eff == CMD_RD) || (cmd_eff == CMD_WR);
    bank_n  = bank_en ? ba_sel : bank_q;
    col_n   = col_en ? addr[COL_W-1:0] : col_q;
    ill_n   = ill_q | bad_access;
  end

  // output latches: registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      col_q  <= '0;
      ill_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_eff;
      bank_q <= bank_n;
      col_q  <= col_n;
      ill_q  <= ill_n;
    end
  end

  assign cmd_code    = cmd_q;
  assign cmd_bank    = bank_q[0];
  assign row_out     = rows_q[bank_q*ROW_W +: ROW_W];
  assign col_out     = col_q;
  assign bank_active = act_q;
  assign illegal     = ill_q;
endmodule

// File: rtl/sdcmd_front_chk.sv
module sdcmd_front_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic                 cke,
  input logic [ROW_W-1:0]     addr,
  input logic [2:0]           cmd_code,
  input logic [COL_W-1:0]     col_out,
  input logic [NUM_BANKS-1:0] bank_active,
  input logic                 suspend,
  input logic                 power_down,
  input logic                 illegal
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(suspend && power_down)); // R9

  AST_DESELECT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd_code == 3'd0)); // R3

  AST_SUSP_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> (cmd_code == 3'd0)); // R8

  AST_SUSP_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> $stable(col_out)); // R8

  AST_PDN_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> (cmd_code == 3'd0)); // R9

  AST_PDN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> (bank_active == '0)); // R9

  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal); // R6

  AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && !power_down && !cs_n && !ras_n && cas_n && !we_n && addr[ROW_W-1])
      |=> (bank_active == '0)); // R7
endmodule

bind sdcmd_front sdcmd_front_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ROW_W     (ROW_W),
  .COL_W     (COL_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .cke         (cke),
  .addr        (addr),
  .cmd_code    (cmd_code),
  .col_out     (col_out),
  .bank_active (bank_active),
  .suspend     (suspend),
  .power_down  (power_down),
  .illegal     (illegal)
);

// File: tb/sdcmd_front_test.sv
`timescale 1ns/1ps
module sdcmd_front_test;
  logic        clk;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n, cke, ba;
  logic [10:0] addr;
  logic [2:0]  cmd_code;
  logic        cmd_bank;
  logic [10:0] row_out;
  logic [7:0]  col_out;
  logic [1:0]  bank_active;
  logic        suspend, power_down, illegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  sdcmd_front uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .row_out(row_out), .col_out(col_out),
    .bank_active(bank_active), .suspend(suspend), .power_down(power_down),
    .illegal(illegal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // {cs,ras,cas,we,cke,ba,addr[11]} -> {code[3],active[2],row[11],col[8],bank}
  localparam logic [41:0] VEC [10] = '{
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,11'h123, 3'd1,2'b01,11'h123,8'h00,1'b0}, // R4 act b0
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,11'h456, 3'd1,2'b11,11'h456,8'h00,1'b1}, // R4 act b1
    {1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,11'h0AB, 3'd2,2'b11,11'h123,8'hAB,1'b0}, // R5 read
    {1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,11'h0CD, 3'd3,2'b11,11'h456,8'hCD,1'b1}, // R5 write
    {1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,11'h7FF, 3'd0,2'b11,11'h456,8'hCD,1'b1}, // R3 deselect
    {1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,11'h7FF, 3'd0,2'b11,11'h456,8'hCD,1'b1}, // R2 nop
    {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,11'h000, 3'd4,2'b10,11'h123,8'hCD,1'b0}, // R7 pre one
    {1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,11'h3FF, 3'd5,2'b10,11'h123,8'hCD,1'b0}, // R11 refresh
    {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,11'h033, 3'd6,2'b10,11'h456,8'hCD,1'b1}, // R11 mode set
    {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,11'h400, 3'd4,2'b00,11'h123,8'hCD,1'b0}  // R7 pre all
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic c, r, ca, w, k, b, input logic [10:0] a);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = b; addr = a;
    @(posedge clk);
    #2;
  endtask

  initial begin
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cke = 1'b1; ba = 1'b0; addr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "code", cmd_code, 0);
    check("R1", "active", bank_active, 0);
    check("R1", "flags", {suspend, power_down, illegal}, 0);
    check("R1", "latches", {cmd_bank, row_out, col_out}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1", "code after release", cmd_code, 0);

    for (int i = 0; i < 10; i++) begin
      drive(VEC[i][41], VEC[i][40], VEC[i][39], VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35:25]);
      check("R2", $sformatf("vec%0d code", i), cmd_code, VEC[i][24:22]);
      check("R7", $sformatf("vec%0d active", i), bank_active, VEC[i][21:20]);
      check("R4", $sformatf("vec%0d row", i), row_out, VEC[i][19:9]);
      check("R5", $sformatf("vec%0d col", i), col_out, VEC[i][8:1]);
      check("R11", $sformatf("vec%0d bank", i), cmd_bank, VEC[i][0]);
    end

    // R6: read to idle bank
    drive(0, 1, 0, 1, 1, 1, 11'h055);
    check("R6", "code", cmd_code, 0);
    check("R6", "col", col_out, 8'hCD);
    check("R6", "bank", cmd_bank, 0);
    check("R6", "illegal", illegal, 1);

    // R8: activate on the edge where cke is low -> executed, then suspend
    drive(0, 0, 1, 1, 0, 0, 11'h0AA);
    check("R8", "code", cmd_code, 1);
    check("R8", "row", row_out, 11'h0AA);
    check("R8", "flags", {suspend, power_down}, 2'b10);
    drive(0, 0, 1, 1, 0, 1, 11'h077);
    check("R8", "ignored code", cmd_code, 0);
    check("R8", "ignored active", bank_active, 2'b01);
    check("R8", "still suspended", suspend, 1);

    // R10: exit edge ignores its command
    drive(0, 1, 0, 1, 1, 0, 11'h011);
    check("R10", "exit code", cmd_code, 0);
    check("R10", "exit col", col_out, 8'hCD);
    check("R10", "suspend cleared", suspend, 0);
    drive(0, 1, 0, 1, 1, 0, 11'h011);
    check("R10", "resumed code", cmd_code, 2);
    check("R5", "resumed col", col_out, 8'h11);
    check("R6", "illegal sticky", illegal, 1);

    // R9: precharge all with cke low -> power-down
    drive(0, 0, 1, 0, 0, 0, 11'h400);
    check("R9", "code", cmd_code, 4);
    check("R9", "active", bank_active, 0);
    check("R9", "flags", {suspend, power_down}, 2'b01);
    drive(0, 0, 1, 1, 0, 1, 11'h077);
    check("R9", "ignored code", cmd_code, 0);
    check("R9", "ignored active", bank_active, 0);
    drive(1, 1, 1, 1, 1, 0, 11'h000);
    check("R10", "pd cleared", power_down, 0);
    drive(0, 0, 1, 1, 1, 1, 11'h077);
    check("R10", "act code", cmd_code, 1);
    check("R10", "act active", bank_active, 2'b10);
    check("R4", "act row", row_out, 11'h077);
    check("R4", "act bank", cmd_bank, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule